// File: doc/BRIEF.md
# In-place row-column transform sequencer

This block keeps one N x N matrix (8 x 8 by default) in a single register store and runs a separable two-dimensional transform through an external one-dimensional N-point engine. A matrix is first loaded one element at a time. Each row is then sent to the engine, and the returned line is written back over that row. After the rows, each column is sent and written back over that column in the same way. The finished matrix then streams out one element at a time.

Once a line has been transformed, its input values are no longer needed. The result therefore replaces them in place. The same store holds the input, the intermediate data that is read in transposed order, and the output, and no second matrix-sized memory is used. The block talks to the engine through a single-cycle request pulse and a completion pulse. Only one request is outstanding at any time.

Top module: `rowcol_inplace_ctrl`

## Requirements
- R1: After reset, `busy`, `out_valid` and `line_start` are all low, and the block is ready to accept a matrix.
- R2: While `busy` is low, each cycle with `in_valid` high stores `in_data` as the next element in row-major order (element index = row*N + column). The cycle after the N*N-th accepted element, `busy` is high.
- R3: During the row pass, request k presents row k on `line_data`, with element i (column i) in bits [i*DW +: DW]. The returned `line_result` replaces row k element by element.
- R4: During the column pass, request k presents column k, with element i (row i) in bits [i*DW +: DW]. The returned `line_result` replaces column k.
- R5: `line_start` is a one-cycle pulse. No new pulse is issued until `line_done` has been seen for the outstanding request. The next pulse follows in the cycle right after that `line_done`.
- R6: A `line_done` pulse that arrives when no request is outstanding has no effect on the stored matrix.
- R7: After the column pass, the matrix streams out on `out_data` in row-major order, with `out_valid` high for N*N consecutive cycles. `busy` falls in the cycle after the last element.
- R8: `in_valid` while `busy` is high is ignored and does not alter the stored matrix.
- R9: Each matrix issues exactly 2*N line requests: N rows, then N columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element valid |
| in_data | input | DW | Input element |
| busy | output | 1 | High from the end of loading until the end of output |
| line_start | output | 1 | Request pulse to the 1-D engine |
| line_data | output | N*DW | Line presented to the engine, element i at bits [i*DW +: DW] |
| line_done | input | 1 | Engine completion pulse |
| line_result | input | N*DW | Line returned by the engine, element i at bits [i*DW +: DW] |
| out_valid | output | 1 | Output element valid |
| out_data | output | DW | Output element |

## Verification
The bench models the engine with a function that depends on both the element position and the request count. Because of this, a swapped row/column index, a result written to the wrong line or the wrong orientation, or a skipped or repeated request all change specific output values. Each of these shows up as a mismatch in the first output stream after the faulty pass. A stuck or early request shows up at the handshake itself: the engine model flags a `line_start` that arrives while a request is still pending. A state machine that leaves the output phase too early or too late changes the count of consecutive `out_valid` cycles, or leaves `busy` wrong one cycle after the stream ends.

// File: rtl/rowcol_inplace_ctrl.sv
module rowcol_inplace_ctrl #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          busy,
  output logic          line_start,
  output logic [N*DW-1:0] line_data,
  input  logic          line_done,
  input  logic [N*DW-1:0] line_result,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int LW   = (N > 1) ? $clog2(N) : 1;
  localparam int PW   = 2 * LW;
  localparam int LAST = N * N - 1;

  typedef enum logic [1:0] {S_LOAD, S_ROWS, S_COLS, S_DRAIN} st_t;

  st_t           st;
  logic [PW-1:0] pos;
  logic [LW-1:0] line;
  logic          pend;
  logic [DW-1:0] mem [N][N];

  wire [LW-1:0] prow     = pos[PW-1:LW];
  wire [LW-1:0] pcol     = pos[LW-1:0];
  wire          pass     = (st == S_ROWS) || (st == S_COLS);
  wire          accept   = in_valid && (st == S_LOAD);
  wire          take     = pass && pend && line_done;
  wire          pos_end  = (pos == PW'(LAST));
  wire          line_end = (line == LW'(N - 1));

  assign busy       = (st != S_LOAD);
  assign line_start = pass && !pend;
  assign out_valid  = (st == S_DRAIN);
  assign out_data   = mem[prow][pcol];

  for (genvar i = 0; i < N; i++) begin : g_line
    assign line_data[i*DW +: DW] = (st == S_COLS) ? mem[i][line] : mem[line][i];
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[prow][pcol] <= in_data;
    end else if (take) begin
      for (int i = 0; i < N; i++) begin
        if (st == S_ROWS) mem[line][i] <= line_result[i*DW +: DW];
        else              mem[i][line] <= line_result[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_LOAD;
      pos  <= '0;
      line <= '0;
      pend <= 1'b0;
    end else begin
      case (st)
        S_LOAD: if (accept) begin
          pos <= pos + 1'b1;
          if (pos_end) st <= S_ROWS;
        end
        S_ROWS, S_COLS: begin
          if (line_start) pend <= 1'b1;
          else if (take) begin
            pend <= 1'b0;
            line <= line + 1'b1;
            if (line_end) st <= (st == S_ROWS) ? S_COLS : S_DRAIN;
          end
        end
        default: begin
          pos <= pos + 1'b1;
          if (pos_end) st <= S_LOAD;
        end
      endcase
    end
  end

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R2
  load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && pos_end) |=> busy);

  // R7
  drain_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pos_end) |=> out_valid);

  // R7
  idle_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos_end) |=> !busy && !out_valid);

  // R8
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_valid && !line_start && !line_done) |=> $stable(out_data) || $past(line_start));
endmodule

// File: tb/tb_rowcol_inplace_ctrl.sv
module tb_rowcol_inplace_ctrl;
  localparam int N  = 8;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [DW-1:0] in_data = '0;
  logic busy, line_start, out_valid;
  logic [N*DW-1:0] line_data, model_res = '0, junk_res = '0;
  logic model_done = 0, junk_done = 0;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  rowcol_inplace_ctrl #(.N(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .busy(busy),
    .line_start(line_start), .line_data(line_data), .line_done(model_done | junk_done),
    .line_result(junk_done ? junk_res : model_res),
    .out_valid(out_valid), .out_data(out_data));

  int checks = 0, fails = 0, nstarts = 0, lat = 3, outn = 0;
  logic [DW-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 1-D engine model: y[i] = 2*x[i] + i + k, k = request number within the matrix
  initial begin
    int cnt = 0, k = 0;
    bit outst = 0;
    logic [N*DW-1:0] cap = '0;
    forever begin
      @(negedge clk);
      model_done = 0;
      if (cnt > 0) begin
        check(!line_start, "R5 start while pending", int'(line_start), 0);
        cnt--;
        if (cnt == 0) begin
          for (int i = 0; i < N; i++)
            model_res[i*DW +: DW] = DW'(2 * int'(cap[i*DW +: DW]) + i + k);
          model_done = 1;
          outst = 0;
        end
      end else if (line_start) begin
        check(!outst, "R5 start overlap", 1, 0);
        cap = line_data;
        k = nstarts % (2 * N);
        nstarts++;
        outst = 1;
        cnt = lat;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (out_valid) begin
      outn++;
      if (exp_q.size() == 0) check(0, "R7 unexpected output", int'(out_data), -1);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R3/R4/R7 output element", int'(out_data), int'(e));
      end
    end
  end

  task automatic run_matrix(input int seed, input int l, input bit gaps, input bit junk);
    int a[N][N];
    int r1[N][N];
    int s0;
    lat = l;
    s0 = nstarts;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) a[r][c] = (seed * 7 + r * 8 + c * 3) % 97;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) r1[r][c] = 2 * a[r][c] + c + r;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) exp_q.push_back(DW'(2 * r1[r][c] + r + N + c));
    for (int e = 0; e < N * N; e++) begin
      if (gaps && (e % 5 == 2)) begin
        in_valid = 0;
        if (junk) begin junk_done = 1; junk_res = {N{16'h7abc}}; end
        @(negedge clk);
        junk_done = 0;
      end
      check(!busy, "R2 busy during load", int'(busy), 0);
      in_valid = 1;
      in_data = DW'(a[e / N][e % N]);
      @(negedge clk);
    end
    check(busy, "R2 busy after last element", int'(busy), 1);
    if (junk) begin
      in_data = 16'hdead;
      while (!out_valid) @(negedge clk);
      in_valid = 0;
    end else in_valid = 0;
    outn = 0;
    while (!out_valid) @(negedge clk);
    while (out_valid) @(negedge clk);
    check(outn == N * N, "R7 consecutive outputs", outn, N * N);
    check(!busy, "R7 busy after drain", int'(busy), 0);
    check(nstarts - s0 == 2 * N, "R9 requests per matrix", nstarts - s0, 2 * N);
    check(exp_q.size() == 0, "R7 leftover expected", exp_q.size(), 0);
    if (junk) begin
      junk_done = 1; junk_res = '1;
      @(negedge clk);
      junk_done = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy, "R1 busy", int'(busy), 0);
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(!line_start, "R1 line_start", int'(line_start), 0);
    run_matrix(1, 3, 0, 0);
    run_matrix(5, 1, 1, 1);   // R6 R8 junk done and input
    run_matrix(9, 6, 1, 1);   // R6 after previous junk done in idle
    run_matrix(0, 2, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule